// File: doc/BRIEF.md
# GPIO Interrupt Controller

This block is a general-purpose I/O port of `NPINS` pins (32 by default) behind a small memory-mapped register interface. Software chooses per pin whether it is an input or an output, moves output levels only through dedicated write-one-to-set and write-one-to-clear registers, and reads back the pin levels after a two-flop synchronizer.

Every pin can also raise an interrupt. Three per-pin configuration vectors together pick the trigger: detection style (edge or level), a dual-edge flag, and a polarity bit. Raw status is kept per pin. A pending view is formed from the raw status, an enable vector and a mask vector, and a single interrupt line is the OR of all pending bits. Edge events latch until software acknowledges them. Level events track the synchronized pin.

Reads are combinational from `bus_addr`. A write takes effect on the rising clock edge where `bus_sel` and `bus_wr` are both high. Register offsets are 0x04 pin levels (read only), 0x08 direction, 0x10 output set, 0x14 output clear, 0x20 interrupt enable, 0x24 raw status (read only), 0x28 pending status (read only), 0x2C mask, 0x30 acknowledge, 0x34 detection style, 0x38 dual-edge and 0x3C polarity.

Top module: `gpio_irq_unit`

## Requirements
- R1: After reset, `pin_oe` is 0, `pin_out` is 0 and `irq` is 0. Offset 0x08 reads all ones. Offsets 0x34 and 0x24 read 0.
- R2: A direction bit (offset 0x08) of 1 makes the pin an input and 0 makes it an output. `pin_oe` bit i equals the inverse of direction bit i from the cycle after the write.
- R3: A write to 0x10 drives high every output bit whose data bit is 1. A write to 0x14 drives low every output bit whose data bit is 1. Zero data bits leave the outputs unchanged. Reads of 0x10 and 0x14 return the output latch.
- R4: Offset 0x04 returns `pin_in` through two flops. A change made before clock edge k appears on the read after edge k+1 and not before.
- R5: When the style bit (0x34) is 0, the dual-edge bit (0x38) is 0 and the polarity bit (0x3C) is 0, a rising transition sets the raw status bit and a falling one does not.
- R6: With style 0, dual-edge 0 and polarity 1, a falling transition sets the raw status bit and a rising one does not.
- R7: With style 0 and dual-edge 1, either transition sets the raw status bit, whatever the polarity bit holds.
- R8: With style 1, raw status follows the synchronized pin each cycle: it is active high for polarity 0 and active low for polarity 1. A write to 0x30 cannot clear it while the condition holds.
- R9: Edge-latched raw status holds until a 1 is written to its bit at 0x30. Zero bits of that write leave status untouched. An edge detected in the same cycle as the acknowledge keeps the bit set.
- R10: Offset 0x28 reads raw AND enable (0x20) AND NOT mask (0x2C). `irq` is 1 exactly when that value is nonzero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write access |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | NPINS | Write data |
| bus_rdata | output | NPINS | Read data for `bus_addr` (combinational) |
| pin_in | input | NPINS | Asynchronous pin levels |
| pin_out | output | NPINS | Output latch levels |
| pin_oe | output | NPINS | Output enable per pin (1 = driven) |
| irq | output | 1 | Combined interrupt |

## Verification
A corrupted configuration or status bit shows up at the next read of its offset and, through `irq`, in the cycle after the fault. A detector that picks the wrong edge or polarity leaves a visible difference in raw status three clock edges after the pin changes. The bench therefore samples each effect at its exact cycle. The R4 check brackets the synchronizer depth from both sides. The acknowledge-collision check lines the write up with the edge-detection cycle, so that a priority error is exposed at once.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
    localparam int unsigned ADDR_W = 8;

    // register offsets, grouped by function
    localparam logic [ADDR_W-1:0] OFS_OUT_SET = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_OUT_CLR = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_DIR     = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_PIN_IN  = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_STYLE   = 8'h34;
    localparam logic [ADDR_W-1:0] OFS_DUAL    = 8'h38;
    localparam logic [ADDR_W-1:0] OFS_POL     = 8'h3C;
    localparam logic [ADDR_W-1:0] OFS_RAW     = 8'h24;
    localparam logic [ADDR_W-1:0] OFS_PEND    = 8'h28;
    localparam logic [ADDR_W-1:0] OFS_ACK     = 8'h30;
    localparam logic [ADDR_W-1:0] OFS_IEN     = 8'h20;
    localparam logic [ADDR_W-1:0] OFS_MASK    = 8'h2C;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int unsigned W      = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] cur_o,
    output logic [W-1:0] prev_o
);
    // STAGES synchronizer flops plus one history flop
    localparam int unsigned DEPTH = STAGES + 1;

    logic [DEPTH-1:0][W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = async_i;
        for (int i = 1; i < DEPTH; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign cur_o  = chain_q[STAGES-1];
    assign prev_o = chain_q[STAGES];
endmodule

// File: rtl/gpio_trig_detect.sv
module gpio_trig_detect #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] cur_i,
    input  logic [W-1:0] prev_i,
    input  logic [W-1:0] style_i,
    input  logic [W-1:0] dual_i,
    input  logic [W-1:0] pol_i,
    output logic [W-1:0] edge_hit_o,
    output logic [W-1:0] level_on_o
);
    for (genvar g = 0; g < W; g++) begin : g_pin
        logic rise, fall;
        assign rise = cur_i[g] & ~prev_i[g];
        assign fall = ~cur_i[g] & prev_i[g];
        always_comb begin
            if (style_i[g])     edge_hit_o[g] = 1'b0;
            else if (dual_i[g]) edge_hit_o[g] = rise | fall;
            else if (pol_i[g])  edge_hit_o[g] = fall;
            else                edge_hit_o[g] = rise;
            level_on_o[g] = pol_i[g] ? ~cur_i[g] : cur_i[g];
        end
    end
endmodule

// File: rtl/gpio_irq_status.sv
module gpio_irq_status #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] style_i,
    input  logic [W-1:0] edge_hit_i,
    input  logic [W-1:0] level_on_i,
    input  logic [W-1:0] ack_i,
    output logic [W-1:0] raw_o
);
    logic [W-1:0] raw_d, raw_q;

    always_comb begin
        for (int i = 0; i < W; i++) begin
            if (style_i[i]) raw_d[i] = level_on_i[i];
            else            raw_d[i] = edge_hit_i[i] | (raw_q[i] & ~ack_i[i]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) raw_q <= '0;
        else        raw_q <= raw_d;
    end

    assign raw_o = raw_q;
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
    import gpio_irq_pkg::*;
#(
    parameter int unsigned NPINS       = 32,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NPINS-1:0]  bus_wdata,
    output logic [NPINS-1:0]  bus_rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe,
    output logic              irq
);
    typedef struct packed {
        logic [NPINS-1:0] dir;
        logic [NPINS-1:0] outl;
        logic [NPINS-1:0] ien;
        logic [NPINS-1:0] imsk;
        logic [NPINS-1:0] style;
        logic [NPINS-1:0] dual;
        logic [NPINS-1:0] pol;
    } cfg_t;

    cfg_t             cfg_d, cfg_q;
    logic             wr_en;
    logic [NPINS-1:0] ack_vec;
    logic [NPINS-1:0] sync_cur, sync_prev;
    logic [NPINS-1:0] edge_hit, level_on;
    logic [NPINS-1:0] raw_q;
    logic [NPINS-1:0] pend;

    assign wr_en   = bus_sel & bus_wr;
    assign ack_vec = (wr_en && bus_addr == OFS_ACK) ? bus_wdata : '0;

    gpio_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(pin_in),
        .cur_o  (sync_cur),
        .prev_o (sync_prev)
    );

    gpio_trig_detect #(.W(NPINS)) u_detect (
        .cur_i     (sync_cur),
        .prev_i    (sync_prev),
        .style_i   (cfg_q.style),
        .dual_i    (cfg_q.dual),
        .pol_i     (cfg_q.pol),
        .edge_hit_o(edge_hit),
        .level_on_o(level_on)
    );

    gpio_irq_status #(.W(NPINS)) u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .style_i   (cfg_q.style),
        .edge_hit_i(edge_hit),
        .level_on_i(level_on),
        .ack_i     (ack_vec),
        .raw_o     (raw_q)
    );

    // configuration register next state
    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            unique case (bus_addr)
                OFS_DIR:     cfg_d.dir   = bus_wdata;
                OFS_OUT_SET: cfg_d.outl  = cfg_q.outl | bus_wdata;
                OFS_OUT_CLR: cfg_d.outl  = cfg_q.outl & ~bus_wdata;
                OFS_IEN:     cfg_d.ien   = bus_wdata;
                OFS_MASK:    cfg_d.imsk  = bus_wdata;
                OFS_STYLE:   cfg_d.style = bus_wdata;
                OFS_DUAL:    cfg_d.dual  = bus_wdata;
                OFS_POL:     cfg_d.pol   = bus_wdata;
                default:     cfg_d       = cfg_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q     <= '0;
            cfg_q.dir <= '1;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign pend = raw_q & cfg_q.ien & ~cfg_q.imsk;

    always_comb begin
        unique case (bus_addr)
            OFS_PIN_IN:  bus_rdata = sync_cur;
            OFS_DIR:     bus_rdata = cfg_q.dir;
            OFS_OUT_SET: bus_rdata = cfg_q.outl;
            OFS_OUT_CLR: bus_rdata = cfg_q.outl;
            OFS_IEN:     bus_rdata = cfg_q.ien;
            OFS_RAW:     bus_rdata = raw_q;
            OFS_PEND:    bus_rdata = pend;
            OFS_MASK:    bus_rdata = cfg_q.imsk;
            OFS_STYLE:   bus_rdata = cfg_q.style;
            OFS_DUAL:    bus_rdata = cfg_q.dual;
            OFS_POL:     bus_rdata = cfg_q.pol;
            default:     bus_rdata = '0;
        endcase
    end

    assign pin_out = cfg_q.outl;
    assign pin_oe  = ~cfg_q.dir;
    assign irq     = |pend;
endmodule

// File: rtl/gpio_irq_unit_chk.sv
module gpio_irq_unit_chk
    import gpio_irq_pkg::*;
#(
    parameter int unsigned NPINS = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [NPINS-1:0]  bus_wdata,
    input logic [NPINS-1:0]  pin_out,
    input logic [NPINS-1:0]  pin_oe,
    input logic              irq,
    input logic [NPINS-1:0]  raw,
    input logic [NPINS-1:0]  style,
    input logic [NPINS-1:0]  ien,
    input logic [NPINS-1:0]  imsk
);
    logic             wr_set, wr_clr, wr_dir;
    logic [NPINS-1:0] ack_now;

    assign wr_set  = bus_sel && bus_wr && bus_addr == OFS_OUT_SET;
    assign wr_clr  = bus_sel && bus_wr && bus_addr == OFS_OUT_CLR;
    assign wr_dir  = bus_sel && bus_wr && bus_addr == OFS_DIR;
    assign ack_now = (bus_sel && bus_wr && bus_addr == OFS_ACK) ? bus_wdata : '0;

    // R3
    set_drives_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_set |=> ((pin_out & $past(bus_wdata)) == $past(bus_wdata)));

    // R3
    clr_drives_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clr |=> ((pin_out & $past(bus_wdata)) == '0));

    // R3
    out_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_set || wr_clr) |=> $stable(pin_out));

    // R2
    dir_to_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_dir |=> (pin_oe == ~$past(bus_wdata)));

    // R9
    edge_status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(raw) & ~$past(style) & ~$past(ack_now)) & ~raw) == '0));

    // R10
    irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((raw & ien & ~imsk) != '0));
endmodule

bind gpio_irq_unit gpio_irq_unit_chk #(.NPINS(NPINS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .pin_out  (pin_out),
    .pin_oe   (pin_oe),
    .irq      (irq),
    .raw      (raw_q),
    .style    (cfg_q.style),
    .ien      (cfg_q.ien),
    .imsk     (cfg_q.imsk)
);

// File: tb/test_gpio_irq_unit.sv
`timescale 1ns/1ps
module test_gpio_irq_unit;
    import gpio_irq_pkg::*;

    localparam int unsigned N = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_sel = 1'b0;
    logic          bus_wr = 1'b0;
    logic [7:0]    bus_addr = '0;
    logic [N-1:0]  bus_wdata = '0;
    logic [N-1:0]  bus_rdata;
    logic [N-1:0]  pin_in = '0;
    logic [N-1:0]  pin_out;
    logic [N-1:0]  pin_oe;
    logic          irq;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    typedef enum int {K_RDATA, K_OUT, K_OE, K_IRQ} kind_e;
    typedef struct {
        kind_e       kind;
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb_q[$];

    always #5 clk = ~clk;

    gpio_irq_unit #(.NPINS(N)) i_gpio_irq_unit (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_sel  (bus_sel),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .pin_in   (pin_in),
        .pin_out  (pin_out),
        .pin_oe   (pin_oe),
        .irq      (irq)
    );

    // monitor: pops expectations and compares them away from the clock edge
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (sb_q.size() > 0) begin
                item_t       it;
                logic [31:0] act;
                it = sb_q.pop_front();
                case (it.kind)
                    K_RDATA: act = bus_rdata;
                    K_OUT:   act = pin_out;
                    K_OE:    act = pin_oe;
                    default: act = {31'b0, irq};
                endcase
                tests++;
                if (act !== it.exp) begin
                    fails++;
                    $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
                end
            end
        end
    end

    // driver tasks
    task automatic expect_sig(input kind_e k, input logic [7:0] addr,
                              input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_addr = addr;
        sb_q.push_back('{kind: k, exp: exp, tag: tag});
    endtask

    task automatic rd(input logic [7:0] addr, input logic [31:0] exp, input string tag);
        expect_sig(K_RDATA, addr, exp, tag);
    endtask

    task automatic wr(input logic [7:0] addr, input logic [31:0] data);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = addr; bus_wdata = data;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic drive_pins(input logic [31:0] v);
        @(negedge clk);
        pin_in = v;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        expect_sig(K_OE,  8'h00, 32'h0, "R1 pin_oe after reset");
        expect_sig(K_OUT, 8'h00, 32'h0, "R1 pin_out after reset");
        expect_sig(K_IRQ, 8'h00, 32'h0, "R1 irq after reset");
        rd(OFS_DIR,   32'hFFFF_FFFF, "R1 direction reads all ones");
        rd(OFS_STYLE, 32'h0, "R1 style reads zero");
        rd(OFS_RAW,   32'h0, "R1 raw status zero");

        // R2 direction
        wr(OFS_DIR, 32'hFFFF_0000);
        expect_sig(K_OE, 8'h00, 32'h0000_FFFF, "R2 low half driven");
        rd(OFS_DIR, 32'hFFFF_0000, "R2 direction readback");

        // R3 set / clear
        wr(OFS_OUT_SET, 32'h0000_00A5);
        expect_sig(K_OUT, 8'h00, 32'h0000_00A5, "R3 set bits");
        wr(OFS_OUT_SET, 32'h0000_0100);
        expect_sig(K_OUT, 8'h00, 32'h0000_01A5, "R3 set keeps zero bits");
        wr(OFS_OUT_CLR, 32'h0000_0005);
        expect_sig(K_OUT, 8'h00, 32'h0000_01A0, "R3 clear bits");
        rd(OFS_OUT_CLR, 32'h0000_01A0, "R3 clear offset reads latch");

        // R4 synchronizer latency: new value after second edge, not first
        @(negedge clk);
        pin_in = 32'h1234_5678;
        rd(OFS_PIN_IN, 32'h0, "R4 not yet after one edge");
        rd(OFS_PIN_IN, 32'h1234_5678, "R4 visible after two edges");
        repeat (2) @(negedge clk);

        // R5 default rising detection
        rd(OFS_RAW, 32'h1234_5678, "R5 rising edges latched");
        wr(OFS_ACK, 32'hFFFF_FFFF);
        rd(OFS_RAW, 32'h0, "R9 acknowledge all");
        drive_pins(32'h0);
        rd(OFS_RAW, 32'h0, "R5 falling ignored");

        // R6 falling polarity on bits 3:0
        wr(OFS_POL, 32'h0000_000F);
        drive_pins(32'h0000_000F);
        rd(OFS_RAW, 32'h0, "R6 rising ignored");
        drive_pins(32'h0);
        rd(OFS_RAW, 32'h0000_000F, "R6 falling latched");
        wr(OFS_ACK, 32'h0000_000F);

        // R7 dual edge on bits 7:4 (polarity bits 3:0 still falling)
        wr(OFS_DUAL, 32'h0000_00F0);
        wr(OFS_POL, 32'h0000_00FF);
        drive_pins(32'h0000_00FF);
        rd(OFS_RAW, 32'h0000_00F0, "R7 rising on dual bits");
        wr(OFS_ACK, 32'h0000_00F0);
        drive_pins(32'h0);
        rd(OFS_RAW, 32'h0000_00FF, "R7 falling on dual bits");

        // R9 partial acknowledge
        wr(OFS_ACK, 32'h0000_000F);
        rd(OFS_RAW, 32'h0000_00F0, "R9 zero bits untouched");
        wr(OFS_ACK, 32'h0000_00F0);
        rd(OFS_RAW, 32'h0, "R9 remaining cleared");

        // R9 edge in the same cycle as acknowledge keeps the bit
        @(negedge clk);
        pin_in = 32'h0000_0010;
        @(negedge clk);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = OFS_ACK; bus_wdata = 32'h0000_0010;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
        rd(OFS_RAW, 32'h0000_0010, "R9 new edge beats acknowledge");
        wr(OFS_ACK, 32'h0000_0010);

        // R8 level: bit 8 active high, bit 9 active low
        wr(OFS_POL, 32'h0000_02FF);
        wr(OFS_STYLE, 32'h0000_0300);
        rd(OFS_RAW, 32'h0000_0200, "R8 active-low pin low");
        wr(OFS_ACK, 32'h0000_0200);
        rd(OFS_RAW, 32'h0000_0200, "R8 acknowledge ineffective while active");
        drive_pins(32'h0000_0310);
        rd(OFS_RAW, 32'h0000_0100, "R8 status follows level");

        // R10 pending and irq
        wr(OFS_IEN, 32'h0000_0101);
        rd(OFS_PEND, 32'h0000_0100, "R10 pending enabled");
        expect_sig(K_IRQ, 8'h00, 32'h1, "R10 irq asserted");
        wr(OFS_MASK, 32'h0000_0100);
        rd(OFS_PEND, 32'h0, "R10 mask hides");
        expect_sig(K_IRQ, 8'h00, 32'h0, "R10 irq masked");
        wr(OFS_MASK, 32'h0);
        wr(OFS_IEN, 32'h0000_0001);
        expect_sig(K_IRQ, 8'h00, 32'h0, "R10 disabled pin silent");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule